// File: doc/BRIEF.md
# Debug Breakpoint Qualification Unit

This unit sits between the debug comparators of a processor core and the core's breakpoint input. Each cycle it receives one event line per watchpoint comparator. A channel's trap is enabled by a software-written bit or by a bit set through the serial debug port; the two are ORed. An event on an enabled channel becomes a breakpoint candidate. The candidate passes to the core only while the path is open. The path is open when the recoverable-state flag is 1 or when non-masked mode is selected. The raw events also go, registered but never gated, to the external watchpoint pins.

The lowest-numbered channels are counted channels. Each has a down-counter that software loads with a preset. Every qualifying event lowers the count by one. The channel raises a breakpoint only in the cycle its count reaches zero, and the count then stays at zero until the next load. There are two external requests. The non-maskable one always reaches the core. The maskable one obeys the same open-path rule as the internal channels. The breakpoint output is a registered one-cycle pulse with a cause vector beside it.

Top module: `dbg_brk_qual`

## Requirements
- R1: A channel's trap enable is the OR of its software bit and its debug-port bit. With neither bit set, an event on that channel never produces a breakpoint.
- R2: With the recoverable flag at 1, an event on an enabled uncounted channel produces a breakpoint pulse.
- R3: With the recoverable flag at 0 and non-masked mode off, no internal channel and no maskable external request produces a breakpoint.
- R4: With non-masked mode on, internal breakpoints pass while the recoverable flag is 0.
- R5: The non-maskable external request produces a breakpoint whatever the flag and the mode.
- R6: The maskable external request passes exactly when the recoverable flag or non-masked mode is 1.
- R7: `wp_pin_o` equals `wp_evt_i` from one cycle earlier, regardless of enables, flag and mode.
- R8: Counted channel k loads `cnt_preset_i[k*CNT_W +: CNT_W]` when `cnt_load_i[k]` is 1, and a load wins over an event in the same cycle. Each enabled event seen while the path is open lowers a nonzero count by one. The breakpoint fires only on the step from 1 to 0. At zero the count holds and further events are ignored until the next load. A preset of 0 therefore never fires.
- R9: While the path is closed (flag 0, non-masked mode off), the counters keep their values.
- R10: `brk_cpu_o` is high for exactly one cycle, one clock after the combined request rises from 0. A request that stays high, even when its source changes, gives no further pulse. `brk_cause_o` is valid with the pulse and is zero otherwise. Bit i (i < NUM_WP) marks channel i. Bit NUM_WP marks the maskable external request. Bit NUM_WP+1 marks the non-maskable one.
- R11: After reset all outputs are 0 and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_evt_i | input | NUM_WP | Watchpoint events from the comparators |
| sw_trap_en_i | input | NUM_WP | Trap enables written by software |
| port_trap_en_i | input | NUM_WP | Trap enables set through the debug port |
| recov_i | input | 1 | Recoverable-state flag |
| nonmask_mode_i | input | 1 | Non-masked mode select |
| ext_brk_mask_i | input | 1 | Maskable external breakpoint request |
| ext_brk_nm_i | input | 1 | Non-maskable external breakpoint request |
| cnt_load_i | input | NUM_CNT | Load strobe, one per counter |
| cnt_preset_i | input | NUM_CNT*CNT_W | Counter preset values, counter k in slice k |
| wp_pin_o | output | NUM_WP | Registered watchpoint pin drive |
| brk_cpu_o | output | 1 | One-cycle breakpoint pulse to the core |
| brk_cause_o | output | NUM_WP+2 | Cause of the current pulse |

## Verification
The hardest case to reach is a counter that stays frozen while the path is closed, because a frozen count cannot be seen at the ports. The stimulus loads a counter, sends several enabled events with the path closed, then opens the path. It then counts the events needed before the pulse appears. Only the untouched preset gives the expected pulse position. A second hard case is a request whose source changes without a gap, which must give one pulse and no more. The stimulus holds a channel event and raises an external request in the very next cycle.

// File: rtl/bkq_pkg.sv
`timescale 1ns/1ps
package bkq_pkg;
  // Merge of the two trap-enable sources for one channel.
  function automatic logic trap_merge(input logic sw_bit, input logic port_bit);
    return sw_bit | port_bit;
  endfunction

  // Whether a maskable breakpoint may reach the core.
  function automatic logic path_open(input logic recov, input logic nonmask);
    return recov | nonmask;
  endfunction
endpackage

// File: rtl/bkq_qualify.sv
`timescale 1ns/1ps
module bkq_qualify #(
  parameter int NUM_WP  = 6,
  parameter int NUM_CNT = 2
) (
  input  logic [NUM_WP-1:0]  wp_evt,
  input  logic [NUM_WP-1:0]  sw_en,
  input  logic [NUM_WP-1:0]  port_en,
  input  logic               recov,
  input  logic               nonmask,
  output logic [NUM_WP-1:0]  direct_hit,
  output logic [NUM_CNT-1:0] count_step,
  output logic               open
);
  logic [NUM_WP-1:0] trap_en;

  assign open = bkq_pkg::path_open(recov, nonmask);

  for (genvar g = 0; g < NUM_WP; g++) begin : g_ch
    assign trap_en[g] = bkq_pkg::trap_merge(sw_en[g], port_en[g]);
    if (g < NUM_CNT) begin : g_counted
      // counted channels reach the core only through their counter
      assign count_step[g] = wp_evt[g] & trap_en[g] & open;
      assign direct_hit[g] = 1'b0;
    end else begin : g_direct
      assign direct_hit[g] = wp_evt[g] & trap_en[g] & open;
    end
  end
endmodule

// File: rtl/bkq_wp_counter.sv
`timescale 1ns/1ps
module bkq_wp_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic             step,
  output logic [CNT_W-1:0] value,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic ld,
    input logic [CNT_W-1:0] pre, input logic stp);
    if (ld)                       return pre;
    else if (stp && cur != '0)    return cur - ONE;
    else                          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= next_count(value, load, preset, step);
  end

  assign expire = step & ~load & (value == ONE);
endmodule

// File: rtl/bkq_out_stage.sv
`timescale 1ns/1ps
module bkq_out_stage #(
  parameter int NUM_WP  = 6,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_WP-1:0]  wp_evt,
  input  logic [CAUSE_W-1:0] cause_now,
  output logic [NUM_WP-1:0]  wp_pin,
  output logic               brk,
  output logic [CAUSE_W-1:0] cause,
  output logic               req_any
);
  logic req_prev;
  logic fire;

  assign req_any = |cause_now;
  assign fire    = req_any & ~req_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_pin   <= '0;
      brk      <= 1'b0;
      cause    <= '0;
      req_prev <= 1'b0;
    end else begin
      wp_pin   <= wp_evt;
      brk      <= fire;
      cause    <= fire ? cause_now : '0;
      req_prev <= req_any;
    end
  end
endmodule

// File: rtl/dbg_brk_qual.sv
`timescale 1ns/1ps
module dbg_brk_qual #(
  parameter int NUM_WP  = 6,
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WP-1:0]        wp_evt_i,
  input  logic [NUM_WP-1:0]        sw_trap_en_i,
  input  logic [NUM_WP-1:0]        port_trap_en_i,
  input  logic                     recov_i,
  input  logic                     nonmask_mode_i,
  input  logic                     ext_brk_mask_i,
  input  logic                     ext_brk_nm_i,
  input  logic [NUM_CNT-1:0]       cnt_load_i,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_preset_i,
  output logic [NUM_WP-1:0]        wp_pin_o,
  output logic                     brk_cpu_o,
  output logic [NUM_WP+1:0]        brk_cause_o
);
  localparam int CAUSE_W      = NUM_WP + 2;
  localparam int CAUSE_EXT_M  = NUM_WP;
  localparam int CAUSE_EXT_NM = NUM_WP + 1;

  logic [NUM_WP-1:0]        direct_hit;
  logic [NUM_CNT-1:0]       count_step;
  logic                     path_open_w;
  logic [NUM_CNT-1:0]       cnt_expire;
  logic [NUM_CNT*CNT_W-1:0] cnt_val_flat;
  logic [CAUSE_W-1:0]       cause_now;
  logic                     brk_req;

  bkq_qualify #(.NUM_WP(NUM_WP), .NUM_CNT(NUM_CNT)) u_qual (
    .wp_evt     (wp_evt_i),
    .sw_en      (sw_trap_en_i),
    .port_en    (port_trap_en_i),
    .recov      (recov_i),
    .nonmask    (nonmask_mode_i),
    .direct_hit (direct_hit),
    .count_step (count_step),
    .open       (path_open_w)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    bkq_wp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cnt_load_i[k]),
      .preset (cnt_preset_i[k*CNT_W +: CNT_W]),
      .step   (count_step[k]),
      .value  (cnt_val_flat[k*CNT_W +: CNT_W]),
      .expire (cnt_expire[k])
    );
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_cause
    if (g < NUM_CNT) begin : g_from_cnt
      assign cause_now[g] = cnt_expire[g];
    end else begin : g_from_hit
      assign cause_now[g] = direct_hit[g];
    end
  end
  assign cause_now[CAUSE_EXT_M]  = ext_brk_mask_i & path_open_w;
  assign cause_now[CAUSE_EXT_NM] = ext_brk_nm_i;

  bkq_out_stage #(.NUM_WP(NUM_WP), .CAUSE_W(CAUSE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_evt    (wp_evt_i),
    .cause_now (cause_now),
    .wp_pin    (wp_pin_o),
    .brk       (brk_cpu_o),
    .cause     (brk_cause_o),
    .req_any   (brk_req)
  );
endmodule

// File: rtl/bkq_checker.sv
`timescale 1ns/1ps
module bkq_checker #(
  parameter int NUM_WP  = 6,
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_WP-1:0]        wp_evt_i,
  input logic [NUM_WP-1:0]        wp_pin_o,
  input logic                     brk_cpu_o,
  input logic                     recov_i,
  input logic                     nonmask_mode_i,
  input logic                     ext_brk_nm_i,
  input logic [NUM_CNT-1:0]       cnt_load_i,
  input logic [NUM_CNT*CNT_W-1:0] cnt_val_flat,
  input logic                     brk_req
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7: pins echo the raw events, never gated
  p_pin_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> wp_pin_o == $past(wp_evt_i));

  // R10: pulse never lasts two cycles
  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_cpu_o |=> !brk_cpu_o);

  // R10: a pulse follows a request seen one cycle earlier
  p_pulse_has_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && brk_cpu_o) |-> $past(brk_req));

  // R3: closed path gives pulses only from the non-maskable request
  p_closed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && brk_cpu_o) |-> $past(ext_brk_nm_i || recov_i || nonmask_mode_i));

  // R9: counters frozen while closed and not loaded
  p_cnt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !recov_i && !nonmask_mode_i && cnt_load_i == '0) |=> $stable(cnt_val_flat));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_zero
    // R8: zero holds until a load
    p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && cnt_val_flat[k*CNT_W +: CNT_W] == '0 && !cnt_load_i[k])
        |=> cnt_val_flat[k*CNT_W +: CNT_W] == '0);
  end
endmodule

bind dbg_brk_qual bkq_checker #(.NUM_WP(NUM_WP), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bkq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wp_evt_i       (wp_evt_i),
  .wp_pin_o       (wp_pin_o),
  .brk_cpu_o      (brk_cpu_o),
  .recov_i        (recov_i),
  .nonmask_mode_i (nonmask_mode_i),
  .ext_brk_nm_i   (ext_brk_nm_i),
  .cnt_load_i     (cnt_load_i),
  .cnt_val_flat   (cnt_val_flat),
  .brk_req        (brk_req)
);

// File: tb/dbg_brk_qual_bench.sv
`timescale 1ns/1ps
module dbg_brk_qual_bench;
  localparam int NW = 6;
  localparam int NC = 2;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]    wp_evt, sw_en, port_en;
  logic             recov, nonmask, ext_m, ext_nm;
  logic [NC-1:0]    cnt_load;
  logic [NC*CW-1:0] cnt_preset;
  logic [NW-1:0]    wp_pin;
  logic             brk;
  logic [NW+1:0]    cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NW-1:0] pins;
    logic          brk;
    logic [NW+1:0] cause;
    string         tag;
  } exp_t;
  exp_t q[$];

  logic [CW-1:0] m_cnt [NC];
  logic          m_prev;

  always #2.5 clk = ~clk;

  dbg_brk_qual #(.NUM_WP(NW), .NUM_CNT(NC), .CNT_W(CW)) u_dbg_brk_qual (
    .clk(clk), .rst_n(rst_n), .wp_evt_i(wp_evt), .sw_trap_en_i(sw_en),
    .port_trap_en_i(port_en), .recov_i(recov), .nonmask_mode_i(nonmask),
    .ext_brk_mask_i(ext_m), .ext_brk_nm_i(ext_nm), .cnt_load_i(cnt_load),
    .cnt_preset_i(cnt_preset), .wp_pin_o(wp_pin), .brk_cpu_o(brk),
    .brk_cause_o(cause)
  );

  task automatic report_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Driver: apply one cycle of stimulus and push the expected outcome.
  task automatic step(input logic [NW-1:0] e, input logic [NW-1:0] s,
                      input logic [NW-1:0] p, input logic rv, input logic nm,
                      input logic em, input logic xn, input logic [NC-1:0] ld,
                      input logic [CW-1:0] p0, input logic [CW-1:0] p1,
                      input string tag);
    exp_t it;
    logic [NW+1:0] cz;
    logic open_now;
    logic req;
    @(negedge clk);
    wp_evt = e; sw_en = s; port_en = p; recov = rv; nonmask = nm;
    ext_m = em; ext_nm = xn; cnt_load = ld; cnt_preset = {p1, p0};
    open_now = rv | nm;
    cz = '0;
    for (int i = 0; i < NW; i++) begin
      logic ena;
      ena = s[i] | p[i];
      if (i < NC) begin
        if (ld[i]) m_cnt[i] = (i == 0) ? p0 : p1;
        else if (e[i] && ena && open_now && m_cnt[i] != '0) begin
          if (m_cnt[i] == CW'(1)) cz[i] = 1'b1;
          m_cnt[i] = m_cnt[i] - CW'(1);
        end
      end else begin
        cz[i] = e[i] & ena & open_now;
      end
    end
    cz[NW]   = em & open_now;
    cz[NW+1] = xn;
    req = |cz;
    it.brk   = req & ~m_prev;
    it.cause = it.brk ? cz : '0;
    it.pins  = e;
    it.tag   = tag;
    m_prev   = req;
    q.push_back(it);
  endtask

  task automatic idle(input logic rv, input string tag);
    step('0, '0, '0, rv, 1'b0, 1'b0, 1'b0, '0, '0, '0, tag);
  endtask

  task automatic hit(input logic [NW-1:0] e, input logic [NW-1:0] s,
                     input logic [NW-1:0] p, input logic rv, input logic nm,
                     input string tag);
    step(e, s, p, rv, nm, 1'b0, 1'b0, '0, '0, '0, tag);
  endtask

  // Monitor: pop and compare, sampled 1 ns after the rising edge.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (wp_pin !== it.pins || brk !== it.brk || cause !== it.cause) begin
          failures++;
          $display("FAIL %s: pins=%b brk=%b cause=%b expected pins=%b brk=%b cause=%b",
                   it.tag, wp_pin, brk, cause, it.pins, it.brk, it.cause);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report_summary();
      $finish;
    end
  end

  initial begin
    wp_evt = '0; sw_en = '0; port_en = '0; recov = 1'b1; nonmask = 1'b0;
    ext_m = 1'b0; ext_nm = 1'b0; cnt_load = '0; cnt_preset = '0;
    m_prev = 1'b0;
    for (int k = 0; k < NC; k++) m_cnt[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (wp_pin !== '0 || brk !== 1'b0 || cause !== '0) begin
      failures++;
      $display("FAIL R11: pins=%b brk=%b cause=%b expected all zero", wp_pin, brk, cause);
    end
    rst_n = 1'b1;

    // R11: counters start at zero, so a counted event does nothing
    hit(6'b000001, 6'b000001, '0, 1'b1, 1'b0, "R11 counter zero");
    idle(1'b1, "R11 idle");

    // R1 / R2: either enable source suffices, recoverable flag at 1
    hit(6'b001000, 6'b001000, '0, 1'b1, 1'b0, "R1 R2 software enable");
    idle(1'b1, "R1 idle");
    hit(6'b010000, '0, 6'b010000, 1'b1, 1'b0, "R1 R2 port enable");
    idle(1'b1, "R1 idle");
    hit(6'b100000, 6'b011111, 6'b011111, 1'b1, 1'b0, "R1 no enable");
    idle(1'b1, "R1 idle");

    // R3: closed path suppresses internal and maskable external
    hit(6'b001100, 6'b001100, '0, 1'b0, 1'b0, "R3 internal masked");
    step('0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0, "R3 R6 ext maskable blocked");
    idle(1'b0, "R3 idle");

    // R4: non-masked mode opens the path with flag 0
    hit(6'b000100, '0, 6'b000100, 1'b0, 1'b1, "R4 non-masked");
    idle(1'b0, "R4 idle");

    // R5: non-maskable external always passes
    step('0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0, "R5 nm ext closed");
    idle(1'b0, "R5 idle");

    // R6: maskable external with flag 1, and with non-masked mode
    step('0, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, '0, "R6 ext maskable open");
    idle(1'b1, "R6 idle");
    step('0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0, '0, "R6 ext maskable nonmask");
    idle(1'b1, "R6 idle");

    // R10: held request gives one pulse; source hand-over gives none
    for (int i = 0; i < 3; i++) hit(6'b000100, 6'b000100, '0, 1'b1, 1'b0, "R10 held");
    step('0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0, '0, "R10 hand-over");
    idle(1'b1, "R10 idle");

    // R7: pins follow events with no enable and a closed path
    hit(6'b101010, '0, '0, 1'b0, 1'b0, "R7 pins ungated a");
    hit(6'b010101, '0, '0, 1'b0, 1'b0, "R7 pins ungated b");
    idle(1'b1, "R7 idle");

    // R8: preset 3 fires on the third event, then holds zero
    step('0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 8'd3, 8'd0, "R8 load 3");
    for (int i = 0; i < 4; i++) begin
      hit(6'b000001, 6'b000001, '0, 1'b1, 1'b0, "R8 count event");
      idle(1'b1, "R8 idle");
    end
    // R8: load wins over an event in the same cycle
    step(6'b000001, 6'b000001, '0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 8'd2, 8'd0, "R8 load vs event");
    hit(6'b000001, '0, 6'b000001, 1'b1, 1'b0, "R8 event 1 of 2");
    idle(1'b1, "R8 idle");
    hit(6'b000001, '0, 6'b000001, 1'b1, 1'b0, "R8 event 2 of 2");
    idle(1'b1, "R8 idle");
    // R8: preset 0 never fires
    step('0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 8'd0, 8'd0, "R8 load 0");
    hit(6'b000001, 6'b000001, '0, 1'b1, 1'b0, "R8 zero preset");
    idle(1'b1, "R8 idle");

    // R9: closed path freezes counter 1, then two open events fire
    step('0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 8'd0, 8'd2, "R9 load 2");
    for (int i = 0; i < 3; i++) begin
      hit(6'b000010, 6'b000010, '0, 1'b0, 1'b0, "R9 closed event");
      idle(1'b0, "R9 idle");
    end
    hit(6'b000010, 6'b000010, '0, 1'b1, 1'b0, "R9 open event 1");
    idle(1'b1, "R9 idle");
    hit(6'b000010, 6'b000010, '0, 1'b1, 1'b0, "R9 open event 2");
    idle(1'b1, "R9 idle");
    idle(1'b1, "drain");

    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    done = 1'b1;
    report_summary();
    $finish;
  end
endmodule